// File: doc/BRIEF.md
# Vector Gather, Scatter and Merge Unit

This block serves a vector machine when data is laid out irregularly. It keeps a small vector register file of eight registers, each 64 elements wide, and runs one of three commands over the first `len` elements, one element per clock. A gather fetches each element from a local data memory at a base address plus a per-element offset taken from an index register. A scatter does the reverse: it writes each element of a data register to the base address plus the offset from an index register. A merge compares two registers element by element as signed numbers. Where the first is larger, it copies an element from a source register into the destination. Everywhere else it leaves the destination alone.

The data memory is external. It is single-port and synchronous, and read data comes back one cycle after the address. Register 0 is never stored. Every read of it returns the element number, so a gather or scatter that uses register 0 as its index walks memory contiguously. This is how vectors are loaded and unloaded. Software issues a command with a one-cycle `cmd_valid` pulse and waits for the one-cycle `done` pulse.

Top module: `vgsm_unit`

## Requirements
- R1: Op code 0 (gather) sets element i of register `cmd_vd` to mem[(base + idx(i)) mod 2^AW] for every i below the length, where idx is register `cmd_vx`. Elements at or above the length keep their values.
- R2: Op code 1 (scatter) writes element i of register `cmd_vd` to mem[(base + idx(i)) mod 2^AW], with idx from register `cmd_vx`. Writes happen in ascending i, so where two elements share an address the highest i is what remains.
- R3: Op code 2 (merge) sets element i of `cmd_vd` to element i of `cmd_vx` only where element i of `cmd_va` is greater than element i of `cmd_vb`, compared as signed two's complement. Other elements are unchanged and the memory is not accessed.
- R4: Register 0 reads as the element number (i zero-extended) in every read role, and writes aimed at register 0 are dropped.
- R5: Count the edge that accepts a command as edge 0. For a gather, `done` is high for one cycle after edge len+1. For a scatter or merge it is high after edge len. Gather and scatter make exactly len memory accesses.
- R6: A length of zero raises `done` in the cycle after edge 0, makes no memory access and changes no register.
- R7: A `cmd_valid` raised while a command is running is ignored. A command presented in the `done` cycle is accepted.
- R8: Op code 3 is reserved and behaves like a length of zero, whatever length is given.
- R9: An in-place gather, with `cmd_vd` equal to `cmd_vx`, uses the original index value for every element.
- R10: While reset is held, `done` and `mem_en` are low.
- R11: A length of 64 processes the whole register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | 0 gather, 1 scatter, 2 merge, 3 reserved |
| cmd_vd | input | 3 | Destination (gather, merge) or data source (scatter) register |
| cmd_vx | input | 3 | Index register (gather, scatter) or merge source register |
| cmd_va | input | 3 | Merge compare left operand register |
| cmd_vb | input | 3 | Merge compare right operand register |
| cmd_base | input | AW | Base address for gather and scatter |
| cmd_len | input | 7 | Element count; values above 64 are treated as 64 |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read |
| done | output | 1 | One-cycle completion pulse |

## Verification
During a gather, the write-back of element k-1 into the register file and the index read for element k fall in the same cycle. When the destination register is also the index register, this pair decides whether later addresses come from fresh or from overwritten values. The bench provokes it with an in-place gather over 40 elements. It then unloads the register through a contiguous scatter and compares the result against a model that computes every address from the original index vector. Random commands, which may pick equal registers, repeat the same judgement.

// File: rtl/vgsm_pkg.sv
package vgsm_pkg;
   typedef enum logic [1:0] {
      OP_GATHER  = 2'd0,
      OP_SCATTER = 2'd1,
      OP_MERGE   = 2'd2,
      OP_RSVD    = 2'd3
   } vgsm_op_e;
endpackage

// File: rtl/vgsm_vrf.sv
module vgsm_vrf #(
   parameter int DW   = 16,
   parameter int NREG = 8,
   parameter int VLEN = 64,
   parameter int NRD  = 4
) (
   input  logic                          clk,
   input  logic                          we,
   input  logic [$clog2(NREG)-1:0]       wreg,
   input  logic [$clog2(VLEN)-1:0]       welem,
   input  logic [DW-1:0]                 wdata,
   input  logic [NRD-1:0][$clog2(NREG)-1:0] rreg,
   input  logic [$clog2(VLEN)-1:0]       relem,
   output logic [NRD-1:0][DW-1:0]        rdata
);
   localparam int RW = $clog2(NREG);
   localparam int EW = $clog2(VLEN);

   if (DW < EW) begin : g_bad_dw
      $error("vgsm_vrf: element width too narrow for element numbers");
   end
   if ((1 << RW) != NREG) begin : g_bad_nreg
      $error("vgsm_vrf: NREG must be a power of two");
   end

   logic [DW-1:0] cells [NREG][VLEN];

   // register 0 is never stored; writes to it are dropped
   always_ff @(posedge clk) begin
      if (we && (wreg != '0)) cells[wreg][welem] <= wdata;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin
         if (rreg[p] == '0) rdata[p] = {{(DW-EW){1'b0}}, relem};
         else               rdata[p] = cells[rreg[p]][relem];
      end
   end
endmodule

// File: rtl/vgsm_seq.sv
module vgsm_seq #(
   parameter int VLEN = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic [$clog2(VLEN+1)-1:0]   len_i,
   input  logic                        drain_i,
   output logic                        busy_o,
   output logic                        act_o,
   output logic [$clog2(VLEN)-1:0]     elem_o,
   output logic                        done_o
);
   localparam int LW = $clog2(VLEN + 1);
   localparam int EW = $clog2(VLEN);

   if ((1 << EW) != VLEN) begin : g_bad_vlen
      $error("vgsm_seq: VLEN must be a power of two");
   end

   logic          busy_q, act_q, tail_q, done_q;
   logic [LW-1:0] cnt_q, len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         act_q  <= 1'b0;
         tail_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         len_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               if (len_i == '0) begin
                  done_q <= 1'b1;
               end else begin
                  busy_q <= 1'b1;
                  act_q  <= 1'b1;
                  cnt_q  <= '0;
                  len_q  <= len_i;
                  tail_q <= drain_i;
               end
            end
         end else if (act_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == len_q - 1'b1) begin
               act_q <= 1'b0;
               if (!tail_q) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign act_o  = act_q;
   assign elem_o = cnt_q[EW-1:0];
   assign done_o = done_q;

   AST_ASCENDING_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      act_q && $past(act_q) |-> cnt_q == LW'($past(cnt_q) + 1'b1)); // R2
   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> cnt_q < len_q); // R11
endmodule

// File: rtl/vgsm_unit.sv
module vgsm_unit
   import vgsm_pkg::*;
#(
   parameter int DW   = 16,
   parameter int AW   = 10,
   parameter int NREG = 8,
   parameter int VLEN = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [1:0]                   cmd_op,
   input  logic [$clog2(NREG)-1:0]      cmd_vd,
   input  logic [$clog2(NREG)-1:0]      cmd_vx,
   input  logic [$clog2(NREG)-1:0]      cmd_va,
   input  logic [$clog2(NREG)-1:0]      cmd_vb,
   input  logic [AW-1:0]                cmd_base,
   input  logic [$clog2(VLEN+1)-1:0]    cmd_len,
   output logic                         mem_en,
   output logic                         mem_we,
   output logic [AW-1:0]                mem_addr,
   output logic [DW-1:0]                mem_wdata,
   input  logic [DW-1:0]                mem_rdata,
   output logic                         done
);
   localparam int RW = $clog2(NREG);
   localparam int EW = $clog2(VLEN);
   localparam int LW = $clog2(VLEN + 1);

   if (AW > DW) begin : g_bad_aw
      $error("vgsm_unit: index elements must cover the address width");
   end

   vgsm_op_e      op_q;
   logic [RW-1:0] vd_q, vx_q, va_q, vb_q;
   logic [AW-1:0] base_q;
   logic          busy, act, accept;
   logic [EW-1:0] elem;
   logic [LW-1:0] eff_len;

   assign accept  = cmd_valid && !busy;
   assign eff_len = (vgsm_op_e'(cmd_op) == OP_RSVD) ? '0 :
                    (cmd_len > LW'(VLEN))           ? LW'(VLEN) : cmd_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_RSVD;
         vd_q   <= '0;
         vx_q   <= '0;
         va_q   <= '0;
         vb_q   <= '0;
         base_q <= '0;
      end else if (accept) begin
         op_q   <= vgsm_op_e'(cmd_op);
         vd_q   <= cmd_vd;
         vx_q   <= cmd_vx;
         va_q   <= cmd_va;
         vb_q   <= cmd_vb;
         base_q <= cmd_base;
      end
   end

   vgsm_seq #(.VLEN(VLEN)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept),
      .len_i   (eff_len),
      .drain_i (vgsm_op_e'(cmd_op) == OP_GATHER),
      .busy_o  (busy),
      .act_o   (act),
      .elem_o  (elem),
      .done_o  (done)
   );

   // read roles: 0 index / merge source, 1 scatter data, 2 and 3 compare operands
   logic [3:0][RW-1:0] rsel;
   logic [3:0][DW-1:0] rd;
   logic               wb_vld_q, merge_hit, vrf_we;
   logic [EW-1:0]      wb_elem_q, vrf_welem;
   logic [DW-1:0]      vrf_wdata;

   assign rsel = {vb_q, va_q, vd_q, vx_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_vld_q  <= 1'b0;
         wb_elem_q <= '0;
      end else begin
         wb_vld_q  <= act && (op_q == OP_GATHER);
         wb_elem_q <= elem;
      end
   end

   assign merge_hit = act && (op_q == OP_MERGE) && ($signed(rd[2]) > $signed(rd[3]));
   assign vrf_we    = wb_vld_q || merge_hit;
   assign vrf_welem = wb_vld_q ? wb_elem_q : elem;
   assign vrf_wdata = wb_vld_q ? mem_rdata : rd[0];

   vgsm_vrf #(.DW(DW), .NREG(NREG), .VLEN(VLEN), .NRD(4)) u_vrf (
      .clk   (clk),
      .we    (vrf_we),
      .wreg  (vd_q),
      .welem (vrf_welem),
      .wdata (vrf_wdata),
      .rreg  (rsel),
      .relem (elem),
      .rdata (rd)
   );

   assign mem_en    = act && ((op_q == OP_GATHER) || (op_q == OP_SCATTER));
   assign mem_we    = act && (op_q == OP_SCATTER);
   assign mem_addr  = base_q + rd[0][AW-1:0];
   assign mem_wdata = rd[1];

   AST_ZERO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (eff_len == '0) |=> done && !mem_en); // R6
   AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_valid |=> $stable(op_q) && $stable(base_q) && $stable(vd_q)); // R7
   AST_WB_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld_q |-> $past(mem_en && !mem_we)); // R1
   AST_MERGE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      merge_hit |-> !mem_en && !wb_vld_q); // R3
endmodule

// File: tb/sim_vgsm_unit.sv
module sim_vgsm_unit;
   localparam int DW = 16, AW = 10, NREG = 8, VLEN = 64, LW = 7;
   localparam int MW = 1 << AW;
   localparam int DUMP = MW - VLEN;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = '0;
   logic [2:0]    cmd_vd = '0, cmd_vx = '0, cmd_va = '0, cmd_vb = '0;
   logic [AW-1:0] cmd_base = '0;
   logic [LW-1:0] cmd_len = '0;
   logic          mem_en, mem_we, done;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   vgsm_unit #(.DW(DW), .AW(AW), .NREG(NREG), .VLEN(VLEN)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_vd(cmd_vd), .cmd_vx(cmd_vx), .cmd_va(cmd_va), .cmd_vb(cmd_vb),
      .cmd_base(cmd_base), .cmd_len(cmd_len), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
   );

   logic [DW-1:0] mem [MW];
   logic          bk_we = 1'b0;
   logic [AW-1:0] bk_addr = '0;
   logic [DW-1:0] bk_data = '0;

   always @(posedge clk) begin
      if (bk_we) mem[bk_addr] <= bk_data;
      else if (mem_en) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr];
      end
   end

   logic [DW-1:0] exp_mem [MW];
   logic [DW-1:0] exp_reg [NREG][VLEN];
   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act_v, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
      end
   endtask

   function automatic logic [DW-1:0] rv(input int r, input int i);
      return (r == 0) ? DW'(i) : exp_reg[r][i];
   endfunction

   task automatic bk(input int a, input logic [DW-1:0] d);
      bk_we = 1'b1; bk_addr = AW'(a); bk_data = d;
      @(negedge clk);
      bk_we = 1'b0;
      exp_mem[a] = d;
   endtask

   function automatic void model(input int op, input int vd, input int vx,
                                 input int va, input int vb, input int base, input int len);
      logic [DW-1:0] tmp [VLEN];
      for (int i = 0; i < VLEN; i++) tmp[i] = rv(vd, i);
      for (int i = 0; i < len; i++) begin
         int a;
         a = (base + int'(rv(vx, i) & (MW - 1))) & (MW - 1);
         if (op == 0) tmp[i] = exp_mem[a];
         else if (op == 1) exp_mem[a] = rv(vd, i);
         else if (op == 2 && $signed(rv(va, i)) > $signed(rv(vb, i))) tmp[i] = rv(vx, i);
      end
      if (vd != 0) for (int i = 0; i < VLEN; i++) exp_reg[vd][i] = tmp[i];
   endfunction

   // issues at the current negedge; returns at the negedge of the done cycle
   task automatic run(input int op, input int vd, input int vx, input int va, input int vb,
                      input int base, input int len, input string req, input bit intr);
      int k, nacc, el, ek, ea;
      el = (op == 3) ? 0 : ((len > VLEN) ? VLEN : len);
      ek = (el == 0) ? 1 : ((op == 0) ? el + 2 : el + 1);
      ea = (op <= 1) ? el : 0;
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_vd = 3'(vd); cmd_vx = 3'(vx);
      cmd_va = 3'(va); cmd_vb = 3'(vb); cmd_base = AW'(base); cmd_len = LW'(len);
      @(negedge clk);
      cmd_valid = 1'b0;
      k = 1; nacc = 0;
      forever begin
         if (mem_en) nacc++;
         if (done || k > 400) break;
         if (intr && k == 3) begin
            cmd_valid = 1'b1; cmd_op = 2'd0; cmd_vd = 3'd1; cmd_vx = 3'd0;
            cmd_base = '0; cmd_len = 7'd5;
         end
         if (intr && k == 4) cmd_valid = 1'b0;
         @(negedge clk);
         k++;
      end
      chk(k == ek, req, "done cycle (R5)", k, ek);
      chk(nacc == ea, req, "memory accesses (R5)", nacc, ea);
      model(op, vd, vx, va, vb, base, el);
   endtask

   task automatic cmp_mem(input string req);
      int bad, first;
      bad = 0; first = -1;
      for (int a = 0; a < MW; a++)
         if (mem[a] !== exp_mem[a]) begin
            bad++;
            if (first < 0) first = a;
         end
      if (first < 0) chk(1'b1, req, "memory image", 0, 0);
      else chk(1'b0, req, $sformatf("memory word %0d", first), int'(mem[first]), int'(exp_mem[first]));
   endtask

   // R4: every register, register 0 included, unloaded via contiguous scatter
   task automatic dump_all(input string req);
      for (int r = 0; r < NREG; r++) run(1, r, 0, 0, 0, DUMP, VLEN, "R4", 1'b0);
      cmp_mem(req);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int seed;
      logic [DW-1:0] keep;
      seed = int'($urandom(32'd7321));
      repeat (4) @(negedge clk);
      chk(done == 1'b0, "R10", "done in reset", int'(done), 0);
      chk(mem_en == 1'b0, "R10", "mem_en in reset", int'(mem_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < MW; a++) bk(a, DW'($urandom));
      // R11: full-length loads of every register
      for (int r = 1; r < NREG; r++) run(0, r, 0, 0, 0, r * 100, 64, "R11", 1'b0);
      dump_all("R1");
      // R6 and R8
      run(0, 1, 2, 0, 0, 0, 0, "R6", 1'b0);
      run(3, 2, 3, 0, 0, 50, 20, "R8", 1'b0);
      dump_all("R8");
      // R2: duplicate indices, highest element must remain
      for (int i = 0; i < 16; i++) bk(100 + i, (i % 3 == 0) ? 16'd5 : 16'd7);
      run(0, 1, 0, 0, 0, 100, 16, "R2", 1'b0);
      run(1, 2, 1, 0, 0, 500, 16, "R2", 1'b0);
      cmp_mem("R2");
      chk(mem[505] === rv(2, 15), "R2", "duplicate winner", int'(mem[505]), int'(rv(2, 15)));
      // R9: in-place gather
      run(0, 3, 3, 0, 0, 200, 40, "R9", 1'b0);
      dump_all("R9");
      // R3: signed compare corners
      bk(300, 16'h8000); bk(301, 16'h7FFF); bk(302, 16'h1234); bk(303, 16'hFFFF);
      bk(310, 16'h7FFF); bk(311, 16'h8000); bk(312, 16'h1234); bk(313, 16'h0001);
      run(0, 4, 0, 0, 0, 300, 4, "R3", 1'b0);
      run(0, 5, 0, 0, 0, 310, 4, "R3", 1'b0);
      keep = rv(6, 0);
      run(2, 6, 7, 4, 5, 0, 4, "R3", 1'b0);
      run(1, 6, 0, 0, 0, DUMP, 64, "R3", 1'b0);
      chk(mem[DUMP] === keep, "R3", "negative not greater", int'(mem[DUMP]), int'(keep));
      chk(mem[DUMP+1] === rv(7, 1), "R3", "positive greater", int'(mem[DUMP+1]), int'(rv(7, 1)));
      cmp_mem("R3");
      // R7: command during a busy scatter is dropped
      run(1, 1, 2, 0, 0, 600, 30, "R7", 1'b1);
      dump_all("R7");
      // random mix
      for (int t = 0; t < 30; t++) begin
         int op;
         op = int'($urandom % 3);
         run(op, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
             int'($urandom % 8), int'($urandom % MW), int'($urandom % 65),
             (op == 0) ? "R1" : (op == 1) ? "R2" : "R3", 1'b0);
         dump_all("R4");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule